// File: doc/BRIEF.md
# Split-Width Host Memory Port

This block gives a host processor random access to a word-addressed buffer memory, 1024 words of 24 bits by default. The host drives an address, a write strobe and a read strobe that run with no timing relation to the core clock. Each strobe goes through a two-stage synchronizer and is turned into edge events in the core clock domain. The address is latched when a strobe falls. Write data is taken into memory when the write strobe rises. An active-high flash clear input zeroes every memory word and the latched address in one core cycle.

The host data bus can be used at its full 24-bit width or as a 16-bit bus. In 16-bit operation an upper-select input picks which part of the word a transfer reaches. With upper-select low, the transfer uses the low 16 bits of the word on data lines 15:0. With upper-select high, it uses the top 8 bits of the word on data lines 7:0. A narrow write changes only its own part and keeps the rest through a read-merge-write on the memory. Host reads and writes act only while the asynchronous host mode input is high. In the other modes, the read strobe only enables the output drivers, and the bus shows the full word at the last latched address.

The bidirectional data bus is split into an input, an output and an output-enable, which the pad ring combines.

Top module: `host_mem_port`

## Requirements
- R1: In host mode with the bus set to wide (`host_wide`=1), a write stores all 24 bits of `host_din` at the address that was present when `wr_n` fell.
- R2: In host mode with the bus set to narrow and `upper_sel`=0, a write replaces word bits 15:0 with `host_din[15:0]` and leaves word bits 23:16 unchanged.
- R3: In host mode with the bus set to narrow and `upper_sel`=1, a write replaces word bits 23:16 with `host_din[7:0]` and leaves word bits 15:0 unchanged.
- R4: In host mode with the bus set to wide, a read shows the whole stored word on `host_dout`, and `upper_sel` has no effect.
- R5: In host mode with the bus set to narrow, a read with `upper_sel`=1 gives word bits 23:16 on `host_dout[7:0]` and zeros on `host_dout[23:8]`. A read with `upper_sel`=0 gives word bits 15:0 on `host_dout[15:0]` and zeros on `host_dout[23:16]`.
- R6: When `host_async_mode`=0, a write strobe cycle leaves the memory unchanged.
- R7: When `host_async_mode`=0, the read strobe does not latch a new address. `host_dout` keeps showing the full 24-bit word at the address latched last.
- R8: `host_oe` equals the inverse of `rd_n` delayed by two core clock edges, in every mode.
- R9: For every core clock edge at which `flash_clr` is high, that edge zeroes all memory words and the latched address. Any host write or address latch attempted while it is high is ignored, so `host_dout` reads zero after such an edge.
- R10: After `wr_n` or `rd_n` has fallen, the latched address stays fixed even if `host_addr` changes before the strobe rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset for synchronizers and address latch |
| flash_clr | input | 1 | Clears the whole memory and the address latch; blocks host access |
| host_async_mode | input | 1 | 1 = host access modes, 0 = other operating modes |
| host_wide | input | 1 | 1 = 24-bit host bus, 0 = 16-bit host bus |
| upper_sel | input | 1 | In 16-bit mode, selects the upper 8-bit part of the word |
| host_addr | input | 10 | Host word address, latched on a strobe falling edge |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_din | input | 24 | Host bus data into the block |
| host_dout | output | 24 | Host bus data out of the block |
| host_oe | output | 1 | Output-driver enable for the host bus |

## Verification
Wide writes and reads show that the whole word passes through unchanged, and that `upper_sel` is ignored at full width. Narrow writes to each part use all-ones filler in the unused data lines. This shows the merge keeps the other part, and that only the selected input lines reach memory. Narrow reads of both parts show the zero fill on the output lines. Mode-off strobes, an address change while a strobe is low, and writes held under flash clear each show that access is blocked. A seeded random run then mixes widths, parts and addresses, including the top address, against a word model in the bench.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic {PART_LOW = 1'b0, PART_HIGH = 1'b1} word_part_e;
  typedef enum logic {BUS_NARROW = 1'b0, BUS_FULL = 1'b1} bus_width_e;
endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic active,
  output logic fell,
  output logic rose
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[CHAIN_W-2:0], strobe_n};
  end

  // synchronized level is chain[STAGES-1]; chain[STAGES] is its previous value
  assign active = ~chain[STAGES-1];
  assign fell   = chain[STAGES] & ~chain[STAGES-1];
  assign rose   = ~chain[STAGES] & chain[STAGES-1];
endmodule

// File: rtl/hmp_mem.sv
module hmp_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (we) begin
      store[addr] <= wdata;
    end
  end

  assign rdata = store[addr];
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_clr,
  input  logic              host_async_mode,
  input  logic              host_wide,
  input  logic              upper_sel,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_oe
);
  import hmp_pkg::*;

  localparam int UPPER_W = DATA_W - NARROW_W;

  // merge host bus data into the stored word according to width and part
  function automatic logic [DATA_W-1:0] merge_word(
    input logic [DATA_W-1:0] old_w, input logic [DATA_W-1:0] bus,
    input bus_width_e width, input word_part_e part);
    logic [DATA_W-1:0] nw;
    nw = old_w;
    if (width == BUS_FULL)      nw = bus;
    else if (part == PART_HIGH) nw[DATA_W-1:NARROW_W] = bus[UPPER_W-1:0];
    else                        nw[NARROW_W-1:0] = bus[NARROW_W-1:0];
    return nw;
  endfunction

  // shape a stored word for the host bus
  function automatic logic [DATA_W-1:0] shape_read(
    input logic [DATA_W-1:0] w, input bus_width_e width, input word_part_e part);
    logic [DATA_W-1:0] o;
    o = '0;
    if (width == BUS_FULL)      o = w;
    else if (part == PART_HIGH) o[UPPER_W-1:0] = w[DATA_W-1:NARROW_W];
    else                        o[NARROW_W-1:0] = w[NARROW_W-1:0];
    return o;
  endfunction

  logic wr_act, wr_fell, wr_rose;
  logic rd_act, rd_fell, rd_rose;
  logic addr_load, wr_commit;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mem_word, mem_wdata;
  bus_width_e width_sel;
  word_part_e part_sel;

  hmp_strobe_sync #(.STAGES(SYNC_STG)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
    .active(wr_act), .fell(wr_fell), .rose(wr_rose));

  hmp_strobe_sync #(.STAGES(SYNC_STG)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n),
    .active(rd_act), .fell(rd_fell), .rose(rd_rose));

  assign width_sel = bus_width_e'(host_wide);
  assign part_sel  = word_part_e'(upper_sel);

  // named events for the checker
  assign addr_load = (wr_fell | rd_fell) & host_async_mode & ~flash_clr;
  assign wr_commit = wr_rose & host_async_mode & ~flash_clr;

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_q <= '0;
    else if (flash_clr) addr_q <= '0;
    else if (addr_load) addr_q <= host_addr;
  end

  assign mem_wdata = merge_word(mem_word, host_din, width_sel, part_sel);

  hmp_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .clr(flash_clr), .we(wr_commit), .addr(addr_q),
    .wdata(mem_wdata), .rdata(mem_word));

  assign host_dout = host_async_mode ? shape_read(mem_word, width_sel, part_sel)
                                     : mem_word;
  assign host_oe   = rd_act;

  logic unused_ok;
  assign unused_ok = wr_act | rd_rose;
endmodule

// File: rtl/hmp_chk.sv
module hmp_chk #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flash_clr,
  input logic              host_async_mode,
  input logic              host_wide,
  input logic              upper_sel,
  input logic              rd_n,
  input logic [DATA_W-1:0] host_dout,
  input logic              host_oe,
  input logic [ADDR_W-1:0] addr_q,
  input logic              addr_load
);
  localparam int UPPER_W = DATA_W - NARROW_W;

  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R5
  narrow_high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_async_mode && !host_wide && upper_sel) |-> host_dout[DATA_W-1:UPPER_W] == '0);

  // R5
  narrow_low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_async_mode && !host_wide && !upper_sel) |-> host_dout[DATA_W-1:NARROW_W] == '0);

  // R8
  oe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (host_oe == !$past(rd_n, 2)));

  // R9
  flash_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_clr |=> (host_dout == '0 && addr_q == '0));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_load && !flash_clr) |=> $stable(addr_q));
endmodule

bind host_mem_port hmp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flash_clr(flash_clr), .host_async_mode(host_async_mode),
  .host_wide(host_wide), .upper_sel(upper_sel), .rd_n(rd_n), .host_dout(host_dout),
  .host_oe(host_oe), .addr_q(addr_q), .addr_load(addr_load));

// File: tb/sim_host_mem_port.sv
`timescale 1ns/1ps
module sim_host_mem_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flash_clr = 1'b0;
  logic        host_async_mode = 1'b1;
  logic        host_wide = 1'b1;
  logic        upper_sel = 1'b0;
  logic [9:0]  host_addr = '0;
  logic        wr_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [23:0] host_din = '0;
  logic [23:0] host_dout;
  logic        host_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [23:0] model [1024];
  logic [9:0]  last_addr = '0;

  always #5 clk = ~clk;

  host_mem_port u0 (
    .clk(clk), .rst_n(rst_n), .flash_clr(flash_clr), .host_async_mode(host_async_mode),
    .host_wide(host_wide), .upper_sel(upper_sel), .host_addr(host_addr), .wr_n(wr_n),
    .rd_n(rd_n), .host_din(host_din), .host_dout(host_dout), .host_oe(host_oe));

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_store(input logic [23:0] old, input logic [23:0] d,
                                            input bit wide, input bit up);
    if (wide) return d;
    if (up)   return {d[7:0], old[15:0]};
    return {old[23:16], d[15:0]};
  endfunction

  function automatic logic [23:0] exp_view(input logic [23:0] w, input bit wide, input bit up);
    if (wide) return w;
    if (up)   return {16'h0000, w[23:16]};
    return {8'h00, w[15:0]};
  endfunction

  task automatic host_write(input logic [9:0] a, input logic [23:0] d, input bit wide, input bit up);
    @(negedge clk);
    host_addr = a; host_din = d; host_wide = wide; upper_sel = up; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    if (host_async_mode && !flash_clr) begin
      model[a] = exp_store(model[a], d, wide, up);
      last_addr = a;
    end
  endtask

  task automatic host_read(input logic [9:0] a, input bit wide, input bit up, input string req);
    @(negedge clk);
    host_addr = a; host_wide = wide; upper_sel = up; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    if (host_async_mode) begin
      last_addr = a;
      check(req, host_dout, exp_view(model[a], wide, up));
    end else begin
      check(req, host_dout, model[last_addr]);
    end
    check("R8 oe while read low", {23'h0, host_oe}, 24'h1);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 oe after read", {23'h0, host_oe}, 24'h0);
  endtask

  task automatic flash_pulse();
    @(negedge clk); flash_clr = 1'b1;
    @(negedge clk); flash_clr = 1'b0;
    for (int i = 0; i < 1024; i++) model[i] = '0;
    last_addr = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 oe after reset", {23'h0, host_oe}, 24'h0);
    flash_pulse();
    check("R9 zero after flash", host_dout, 24'h0);

    // R1, R4 wide path
    host_write(10'd5, 24'hA5C3E1, 1'b1, 1'b0);
    host_read(10'd5, 1'b1, 1'b0, "R1 wide write/read");
    host_read(10'd5, 1'b1, 1'b1, "R4 upper_sel ignored at wide");
    // R2, R3 narrow merges with all-ones filler
    host_write(10'd5, 24'hFF1234, 1'b0, 1'b0);
    host_read(10'd5, 1'b1, 1'b0, "R2 lower narrow write");
    host_write(10'd5, 24'hFFFF7E, 1'b0, 1'b1);
    host_read(10'd5, 1'b1, 1'b0, "R3 upper narrow write");
    check("R3 literal", model[5], 24'h7E1234);
    // R5 narrow reads
    host_read(10'd5, 1'b0, 1'b1, "R5 narrow upper read");
    host_read(10'd5, 1'b0, 1'b0, "R5 narrow lower read");
    // R6 write outside host mode
    host_async_mode = 1'b0;
    host_write(10'd5, 24'h111111, 1'b1, 1'b0);
    // R7 read outside host mode: no new address
    host_read(10'd9, 1'b1, 1'b0, "R7 read strobe only enables output");
    host_async_mode = 1'b1;
    host_read(10'd5, 1'b1, 1'b0, "R6 write ignored outside host mode");
    // R10 address changes while strobe low
    @(negedge clk);
    host_addr = 10'd20; host_din = 24'h0BCDEF; host_wide = 1'b1; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    host_addr = 10'd21;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    model[20] = 24'h0BCDEF;
    host_read(10'd20, 1'b1, 1'b0, "R10 write went to latched address");
    host_read(10'd21, 1'b1, 1'b0, "R10 later address untouched");
    // R9 write held under flash clear
    host_write(10'd1023, 24'h777777, 1'b1, 1'b0);
    @(negedge clk); flash_clr = 1'b1;
    host_write(10'd30, 24'h123456, 1'b1, 1'b0);
    @(negedge clk); flash_clr = 1'b0;
    for (int i = 0; i < 1024; i++) model[i] = '0;
    host_read(10'd30, 1'b1, 1'b0, "R9 write under flash ignored");
    host_read(10'd1023, 1'b1, 1'b0, "R9 memory cleared");
    host_read(10'd5, 1'b1, 1'b0, "R9 memory cleared");

    // seeded random mix
    for (int k = 0; k < 120; k++) begin
      logic [9:0] a;
      bit w, u;
      a = ($urandom % 9 == 0) ? 10'd1023 : 10'($urandom % 8);
      w = ($urandom % 2) == 1;
      u = ($urandom % 2) == 1;
      if ($urandom % 2 == 0) host_write(a, 24'($urandom), w, u);
      else host_read(a, w, u, w ? "R4 random read" : "R5 random read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule